// File: doc/BRIEF.md
# Serial Port Command Decoder and Chip-Select Driver

This block sits beside the data path of a multi-format serial port and turns writes to two control words into control signals. The first word, the format word, holds the frame-format code and the flash-mode bit. The block decodes the code into one-hot mode selects so that the shifters and FIFO logic can choose their behaviour. The second word, the command word, holds the enables, the chip-select index and level, and three command bits. Those command bits are port reset, transmit FIFO clear and receive FIFO clear.

A small state machine issues the command pulses. It has three states. `ST_IDLE` means no command is pending. `ST_PORT_RST` drives both FIFO clear pulses and the busy clear pulse. `ST_FIFO_CLR` drives only the FIFO clear pulses that the last write asked for. Any state moves to `ST_PORT_RST` on a command write with the reset bit set. Otherwise it moves to `ST_FIFO_CLR` on a command write with a clear bit set, and to `ST_IDLE` in every other case. Each pulse therefore lasts one clock unless the next write asks for the same pulse again.

The command bits clear themselves: they always read back as zero. In flash mode, every command write drives one of the chip-select lines to the level bit. A port reset in flash mode forces that level to 1, which is the inactive level. The block also presents two fixed identification words.

Top module: `sport_ctrl_cs`

## Requirements
- R1: After reset, both control words read 0, all chip-select lines are 1, no pulse is active, flash_mode is 0, and fmt_sel selects code 0.
- R2: Format-word bits 14:12 hold the frame code. The codes are 0 SSP, 1 SPI, 2 Microwire, 3 I2S and 4 AC97. fmt_sel bit N is 1 exactly when the code is N, and codes 5 to 7 select no mode. flash_mode follows bit 11. Both take effect from the clock edge that samples the write.
- R3: A command write with bit 6 (port reset) set makes tx_fifo_clr, rx_fifo_clr and busy_clr all 1 in the cycle after the write edge.
- R4: A command write with bit 3 (transmit clear) and/or bit 2 (receive clear) set, and bit 6 clear, pulses only the matching FIFO clear in the next cycle. busy_clr stays 0.
- R5: ctl_rd_data returns the last command word with bits 2, 3 and 6 forced to 0. Every other bit reads back as written, except as R8 states.
- R6: port_en, txd_oe, rx_en and tx_en follow command bits 0, 1, 7 and 8.
- R7: In flash mode, a command write drives chip-select line idx (bits 11:10) to level bit 9. The other lines keep their level.
- R8: In flash mode, a command write with bit 6 set drives the selected line to 1 and reads back bit 9 as 1, whatever bit 9 was.
- R9: Outside flash mode, command writes leave every chip-select line unchanged, and bit 9 reads back as written.
- R10: id_version reads 0x00011901 and id_features reads 0x660F0F1F.
- R11: A pulse lasts one cycle when no write follows. On back-to-back writes, each write's pulses appear in the cycle after its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_wr | input | 1 | Write strobe for the format word |
| fmt_wdata | input | 32 | Format word write data |
| ctl_wr | input | 1 | Write strobe for the command word |
| ctl_wdata | input | 32 | Command word write data |
| fmt_rd_data | output | 32 | Format word readback |
| ctl_rd_data | output | 32 | Command word readback with command bits cleared |
| fmt_sel | output | 5 | One-hot frame-mode select |
| flash_mode | output | 1 | Chip-select (flash) mode active |
| port_en | output | 1 | Port enable |
| txd_oe | output | 1 | Transmit data output enable |
| rx_en | output | 1 | Receive enable |
| tx_en | output | 1 | Transmit enable |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| busy_clr | output | 1 | One-cycle busy-state clear |
| cs_line | output | 4 | Chip-select levels, 1 inactive |
| id_version | output | 32 | Version identification word |
| id_features | output | 32 | Feature identification word |

## Verification
The hardest case to reach is a port reset in flash mode with the level bit written as 0. It must still drive the selected line high, so the bench first drives that line low with an ordinary flash write. Only then can the forced level be seen. The stimulus sweeps every index, level and reset combination in flash mode. A bench model tracks all four lines, so a write that disturbs an unselected line is caught. Two back-to-back writes that ask for different clears check that each pulse belongs to its own write.

// File: rtl/sport_ctrl_pkg.sv
package sport_ctrl_pkg;
    localparam int CW        = 32;
    // command word bit positions
    localparam int B_EN      = 0;
    localparam int B_TXOE    = 1;
    localparam int B_RXCLR   = 2;
    localparam int B_TXCLR   = 3;
    localparam int B_RST     = 6;
    localparam int B_RXEN    = 7;
    localparam int B_TXEN    = 8;
    localparam int B_LVL     = 9;
    localparam int B_IDX_LO  = 10;
    // format word bit positions
    localparam int B_FLASH   = 11;
    localparam int FMT_LO    = 12;
    localparam int FMT_W     = 3;
    localparam int NUM_FMT   = 5;

    localparam logic [CW-1:0] VERSION_WORD = 32'h0001_1901;
    localparam logic [CW-1:0] FEATURE_WORD = 32'h660F_0F1F;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PORT_RST = 2'd1,
        ST_FIFO_CLR = 2'd2
    } cmd_state_e;

    typedef enum logic [FMT_W-1:0] {
        FMT_SSP   = 3'd0,
        FMT_SPI   = 3'd1,
        FMT_UWIRE = 3'd2,
        FMT_I2S   = 3'd3,
        FMT_AC97  = 3'd4
    } frame_fmt_e;
endpackage

// File: rtl/sport_fmt_decode.sv
module sport_fmt_decode
    import sport_ctrl_pkg::*;
#(
    parameter int W    = CW,
    parameter int NFMT = NUM_FMT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  fmt_q,
    output logic [NFMT-1:0] fmt_sel,
    output logic          flash_mode
);
    logic [FMT_W-1:0] code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  fmt_q <= '0;
        else if (wr) fmt_q <= wdata;
    end

    assign code       = fmt_q[FMT_LO +: FMT_W];
    assign flash_mode = fmt_q[B_FLASH];

    for (genvar i = 0; i < NFMT; i++) begin : g_sel
        assign fmt_sel[i] = (code == FMT_W'(i));
    end

    // R2
    fmt_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (flash_mode == $past(wdata[B_FLASH])));
    // R2
    fmt_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (wdata[FMT_LO +: FMT_W] == 3'd4) |=> fmt_sel[4]);
endmodule

// File: rtl/sport_cmd_fsm.sv
module sport_cmd_fsm
    import sport_ctrl_pkg::*;
#(
    parameter int W = CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          flash,
    output logic [W-1:0]  ctl_q,
    output logic          tx_clr,
    output logic          rx_clr,
    output logic          busy_clr
);
    localparam logic [W-1:0] SC_MASK  = (W'(1) << B_RST) | (W'(1) << B_TXCLR) | (W'(1) << B_RXCLR);
    localparam logic [W-1:0] LVL_MASK = W'(1) << B_LVL;

    cmd_state_e state_q, state_d;
    logic [1:0] clr_req_q;          // {tx, rx}
    logic       rst_cmd, tx_cmd, rx_cmd;

    assign rst_cmd = wdata[B_RST];
    assign tx_cmd  = wdata[B_TXCLR];
    assign rx_cmd  = wdata[B_RXCLR];

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_PORT_RST, ST_FIFO_CLR: begin
                if (wr && rst_cmd)                state_d = ST_PORT_RST;
                else if (wr && (tx_cmd || rx_cmd)) state_d = ST_FIFO_CLR;
                else                               state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command word and latched clear request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            clr_req_q <= '0;
        end else if (wr) begin
            ctl_q     <= (wdata & ~SC_MASK) | ((flash && rst_cmd) ? LVL_MASK : '0);
            clr_req_q <= {tx_cmd, rx_cmd};
        end
    end

    // outputs
    always_comb begin
        tx_clr   = 1'b0;
        rx_clr   = 1'b0;
        busy_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PORT_RST: begin
                tx_clr   = 1'b1;
                rx_clr   = 1'b1;
                busy_clr = 1'b1;
            end
            ST_FIFO_CLR: begin
                tx_clr = clr_req_q[1];
                rx_clr = clr_req_q[0];
            end
            default: ;
        endcase
    end

    // R3
    port_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && wdata[B_RST] |=> tx_clr && rx_clr && busy_clr);
    // R4
    tx_only_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && wdata[B_TXCLR] && !wdata[B_RXCLR] && !wdata[B_RST] |=> tx_clr && !rx_clr && !busy_clr);
    // R5
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !ctl_q[B_RST] && !ctl_q[B_TXCLR] && !ctl_q[B_RXCLR]);
    // R11
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr || rx_clr || busy_clr) && !wr |=> !tx_clr && !rx_clr && !busy_clr);
endmodule

// File: rtl/sport_cs_driver.sv
module sport_cs_driver #(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              flash,
    input  logic [IDX_W-1:0]  idx,
    input  logic              lvl,
    input  logic              port_rst,
    output logic [NUM_CS-1:0] cs_q
);
    logic lvl_eff;
    assign lvl_eff = lvl | port_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cs_q <= '1;
        else if (wr && flash && (int'(idx) < NUM_CS))
            cs_q[idx] <= lvl_eff;
    end

    // R8
    cs_rst_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && flash && port_rst |=> cs_q[$past(idx)]);
    // R9
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && flash) |=> $stable(cs_q));
endmodule

// File: rtl/sport_ctrl_cs.sv
module sport_ctrl_cs
    import sport_ctrl_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_wr,
    input  logic [CW-1:0]     fmt_wdata,
    input  logic              ctl_wr,
    input  logic [CW-1:0]     ctl_wdata,
    output logic [CW-1:0]     fmt_rd_data,
    output logic [CW-1:0]     ctl_rd_data,
    output logic [NUM_FMT-1:0] fmt_sel,
    output logic              flash_mode,
    output logic              port_en,
    output logic              txd_oe,
    output logic              rx_en,
    output logic              tx_en,
    output logic              tx_fifo_clr,
    output logic              rx_fifo_clr,
    output logic              busy_clr,
    output logic [NUM_CS-1:0] cs_line,
    output logic [CW-1:0]     id_version,
    output logic [CW-1:0]     id_features
);
    sport_fmt_decode #(.W(CW), .NFMT(NUM_FMT)) u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (fmt_wr),
        .wdata      (fmt_wdata),
        .fmt_q      (fmt_rd_data),
        .fmt_sel    (fmt_sel),
        .flash_mode (flash_mode)
    );

    sport_cmd_fsm #(.W(CW)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .flash    (flash_mode),
        .ctl_q    (ctl_rd_data),
        .tx_clr   (tx_fifo_clr),
        .rx_clr   (rx_fifo_clr),
        .busy_clr (busy_clr)
    );

    sport_cs_driver #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .flash    (flash_mode),
        .idx      (ctl_wdata[B_IDX_LO +: IDX_W]),
        .lvl      (ctl_wdata[B_LVL]),
        .port_rst (ctl_wdata[B_RST]),
        .cs_q     (cs_line)
    );

    assign port_en     = ctl_rd_data[B_EN];
    assign txd_oe      = ctl_rd_data[B_TXOE];
    assign rx_en       = ctl_rd_data[B_RXEN];
    assign tx_en       = ctl_rd_data[B_TXEN];
    assign id_version  = VERSION_WORD;
    assign id_features = FEATURE_WORD;

    // R6
    enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (tx_en == $past(ctl_wdata[B_TXEN])) && (port_en == $past(ctl_wdata[B_EN])));
    // R7
    cs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && flash_mode && !ctl_wdata[B_RST] |=> cs_line[$past(ctl_wdata[B_IDX_LO +: IDX_W])] == $past(ctl_wdata[B_LVL]));
endmodule

// File: tb/sport_ctrl_cs_test.sv
module sport_ctrl_cs_test;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_wr = 1'b0;
    logic [31:0] fmt_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] fmt_rd_data, ctl_rd_data, id_version, id_features;
    logic [4:0]  fmt_sel;
    logic        flash_mode, port_en, txd_oe, rx_en, tx_en;
    logic        tx_fifo_clr, rx_fifo_clr, busy_clr;
    logic [3:0]  cs_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [3:0] cs_exp = 4'hF;

    always #(CLK_P/2) clk = ~clk;

    sport_ctrl_cs uut (
        .clk(clk), .rst_n(rst_n),
        .fmt_wr(fmt_wr), .fmt_wdata(fmt_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .fmt_rd_data(fmt_rd_data), .ctl_rd_data(ctl_rd_data),
        .fmt_sel(fmt_sel), .flash_mode(flash_mode),
        .port_en(port_en), .txd_oe(txd_oe), .rx_en(rx_en), .tx_en(tx_en),
        .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr), .busy_clr(busy_clr),
        .cs_line(cs_line), .id_version(id_version), .id_features(id_features)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fmt_write(input logic [31:0] d);
        @(negedge clk); fmt_wr = 1'b1; fmt_wdata = d;
        @(negedge clk); fmt_wr = 1'b0;
    endtask

    task automatic ctl_write(input logic [31:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic check_pulses(input bit t, input bit r, input bit b, input string req);
        chk({tx_fifo_clr, rx_fifo_clr, busy_clr} == {t, r, b}, req,
            32'({tx_fifo_clr, rx_fifo_clr, busy_clr}), 32'({t, r, b}));
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctl_rd_data == 0 && fmt_rd_data == 0, "R1", ctl_rd_data, 0);
        chk(cs_line == 4'hF, "R1", 32'(cs_line), 32'hF);
        check_pulses(0, 0, 0, "R1");
        chk(fmt_sel == 5'b00001 && !flash_mode, "R1", 32'(fmt_sel), 1);
        // R10 identification words
        chk(id_version == 32'h0001_1901, "R10", id_version, 32'h0001_1901);
        chk(id_features == 32'h660F_0F1F, "R10", id_features, 32'h660F_0F1F);

        // R2 sweep every code with and without flash bit
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 2; f++) begin
                logic [31:0] d;
                d = (32'(c) << 12) | (32'(f) << 11) | 32'h0000_00A5;
                fmt_write(d);
                chk(fmt_sel == ((c < 5) ? 5'(1 << c) : 5'b0), "R2", 32'(fmt_sel), (c < 5) ? 32'(1 << c) : 0);
                chk(flash_mode == f[0] && fmt_rd_data == d, "R2", fmt_rd_data, d);
            end
        end

        // non-flash: command sweep over bits 2,3,6 and level
        fmt_write(32'h0000_1000);
        for (int m = 0; m < 16; m++) begin
            logic [31:0] d;
            bit rs, tc, rc;
            rs = m[0]; tc = m[1]; rc = m[2];
            d = 32'h0000_0183 | (32'(m[3]) << 9) | (32'(rs) << 6) | (32'(tc) << 3) | (32'(rc) << 2) | (32'(m & 3) << 10);
            ctl_write(d);
            // R5 readback with command bits cleared
            chk(ctl_rd_data == (d & ~32'h4C), "R5", ctl_rd_data, d & ~32'h4C);
            // R9 no chip-select change outside flash mode
            chk(cs_line == cs_exp, "R9", 32'(cs_line), 32'(cs_exp));
            // R6 enables
            chk({tx_en, rx_en, txd_oe, port_en} == 4'hF, "R6", 32'({tx_en, rx_en, txd_oe, port_en}), 32'hF);
            // R3 / R4 pulses
            if (rs) check_pulses(1, 1, 1, "R3");
            else    check_pulses(tc, rc, 0, "R4");
            @(negedge clk);
            // R11 pulse lasts one cycle
            check_pulses(0, 0, 0, "R11");
        end

        // R6 enables low
        ctl_write(32'h0);
        chk({tx_en, rx_en, txd_oe, port_en} == 4'h0, "R6", 32'({tx_en, rx_en, txd_oe, port_en}), 0);

        // flash mode sweep
        fmt_write(32'h0000_0800);
        for (int i = 0; i < 4; i++) begin
            // drive low first so a forced high is visible
            ctl_write(32'(i) << 10);
            cs_exp[i] = 1'b0;
            chk(cs_line == cs_exp, "R7", 32'(cs_line), 32'(cs_exp));
            for (int l = 0; l < 2; l++) begin
                for (int r = 0; r < 2; r++) begin
                    logic [31:0] d;
                    d = (32'(i) << 10) | (32'(l) << 9) | (32'(r) << 6) | 32'h1;
                    ctl_write(d);
                    cs_exp[i] = l[0] | r[0];
                    if (r != 0) begin
                        chk(cs_line == cs_exp, "R8", 32'(cs_line), 32'(cs_exp));
                        chk(ctl_rd_data == ((d & ~32'h4C) | 32'h200), "R8", ctl_rd_data, (d & ~32'h4C) | 32'h200);
                    end else begin
                        chk(cs_line == cs_exp, "R7", 32'(cs_line), 32'(cs_exp));
                    end
                end
            end
            ctl_write(32'(i) << 10);
            cs_exp[i] = 1'b0;
            chk(cs_line == cs_exp, "R7", 32'(cs_line), 32'(cs_exp));
        end

        // R11 back-to-back writes with different clears
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 32'h4;
        @(negedge clk); ctl_wdata = 32'h8;
        check_pulses(0, 1, 0, "R11");
        @(negedge clk); ctl_wr = 1'b0;
        check_pulses(1, 0, 0, "R11");
        @(negedge clk);
        check_pulses(0, 0, 0, "R11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule